// File: doc/BRIEF.md
# Timer Count-Source Selector

This block makes the single-cycle count enable that advances a timer/counter. It runs on the system I/O clock. A 3-bit select field picks the source of that enable. The choices are: no counting, every clock, one of four divided rates taken from a shared free-running prescaler, or edges seen on an asynchronous external clock pin.

The prescaler is a 10-bit counter that never stops. A clear strobe sets it back to zero so that divided ticks can be realigned to a known moment. The external pin has its own path, which never passes through the prescaler. The pin is sampled by two flops clocked on the falling clock edge. A rising-edge history register then compares successive samples, and each edge of the chosen polarity becomes one enable pulse. The pin must hold each level for more than one system clock cycle, so its frequency stays below half the system clock.

The downstream counter, its compare and overflow logic, interrupts and any register access are outside this block.

Top module: `timer_clk_select`

## Requirements
- R1: While reset is asserted `countEn` is 0. The synchronizer and edge-history flops reset to 0. If the pin is already high when reset is released, no enable pulse results in either external mode.
- R2: With `clkSel` = 3'b000, `countEn` stays 0.
- R3: With `clkSel` = 3'b001, `countEn` is 1 on every cycle, starting one cycle after the select is applied.
- R4: With `clkSel` = 3'b010, 3'b011, 3'b100 or 3'b101, `countEn` pulses for exactly one cycle once every 8, 64, 256 or 1024 cycles, in that order. A pulse is produced when the prescaler's low 3, 6, 8 or 10 bits are all ones.
- R5: Take the clock edge that samples `preClear` high as cycle 0. At that edge the prescaler is set to 0; on every other edge it increments by one. With a divided rate of N selected, the first enable pulse is therefore seen after edge N and the next after edge 2N.
- R6: With `clkSel` = 3'b111, each rising pin edge gives exactly one `countEn` pulse. With 3'b110, each falling pin edge does. Edges of the other polarity give none.
- R7: The first clock edge at which the downstream counter samples `countEn` high comes between 2.5 and 3.5 clock periods after the pin edge that caused it.
- R8: The external path bypasses the prescaler. Holding `preClear` high has no effect on external pulses or their latency.
- R9: The edge detector runs whatever the select. Moving the select between external and other modes while the pin is steady produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System I/O clock |
| rst | input | 1 | Synchronous active-high reset |
| clkSel | input | 3 | Count-source select |
| preClear | input | 1 | Prescaler clear strobe |
| extPin | input | 1 | Asynchronous external clock pin |
| countEn | output | 1 | One-cycle count enable for the timer |

## Verification
Some properties are checked on every cycle. These are: a quiet output when stopped, a continuous output at the direct rate, single-cycle pulses in the divided and external modes, a one-hot source decode, and the prescaler clearing or incrementing by one. Other behaviour can only be shown by the bench scenarios, because each depends on an exact cycle count or on pin timing inside a clock period. The bench measures the 2.5-to-3.5-cycle pin latency at several sub-cycle offsets, counts pulses per polarity, and times the first and second divided pulses after a clear. It also confirms there is no pulse after reset release with the pin high, and none from select changes while the pin is steady.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int NUM_TAPS = 4;

  typedef enum logic [2:0] {
    SEL_STOP     = 3'd0,
    SEL_DIV1     = 3'd1,
    SEL_DIV8     = 3'd2,
    SEL_DIV64    = 3'd3,
    SEL_DIV256   = 3'd4,
    SEL_DIV1024  = 3'd5,
    SEL_EXT_FALL = 3'd6,
    SEL_EXT_RISE = 3'd7
  } srcSel_e;

  typedef struct packed {
    logic                direct;
    logic [NUM_TAPS-1:0] tapPick;
    logic                extFall;
    logic                extRise;
  } srcStrobe_t;

  localparam int STROBE_W = $bits(srcStrobe_t);
endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter int PRE_W    = 10,
  parameter int TAP0_LOG = 3,
  parameter int TAP1_LOG = 6,
  parameter int TAP2_LOG = 8,
  parameter int TAP3_LOG = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         preClear,
  output logic [PRE_W-1:0]             preVal,
  output logic [tcs_pkg::NUM_TAPS-1:0] tapHit
);
  localparam int TAP_LOG [tcs_pkg::NUM_TAPS] = '{TAP0_LOG, TAP1_LOG, TAP2_LOG, TAP3_LOG};

  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk) begin
    if (rst || preClear) preCnt <= '0;
    else                 preCnt <= preCnt + 1'b1;
  end

  for (genvar i = 0; i < tcs_pkg::NUM_TAPS; i++) begin : g_tap
    assign tapHit[i] = &preCnt[TAP_LOG[i]-1:0];
  end

  assign preVal = preCnt;
endmodule

// File: rtl/tcs_edge_sync.sv
module tcs_edge_sync #(
  parameter int ARM_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic extPin,
  output logic riseHit,
  output logic fallHit
);
  logic syncA, syncB, histQ;
  logic [ARM_W-1:0] armCnt;
  logic armed;

  always_ff @(negedge clk) begin
    if (rst) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= extPin;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      histQ  <= 1'b0;
      armCnt <= '0;
    end else begin
      histQ <= syncB;
      if (armCnt != '1) armCnt <= armCnt + 1'b1;
    end
  end

  assign armed   = (armCnt == '1);
  assign riseHit = armed &  syncB & ~histQ;
  assign fallHit = armed & ~syncB &  histQ;
endmodule

// File: rtl/tcs_ctrl.sv
module tcs_ctrl
  import tcs_pkg::*;
(
  input  logic [2:0]  clkSel,
  output srcStrobe_t  strobe
);
  always_comb begin
    strobe = '0;
    unique case (srcSel_e'(clkSel))
      SEL_STOP:     ;
      SEL_DIV1:     strobe.direct     = 1'b1;
      SEL_DIV8:     strobe.tapPick[0] = 1'b1;
      SEL_DIV64:    strobe.tapPick[1] = 1'b1;
      SEL_DIV256:   strobe.tapPick[2] = 1'b1;
      SEL_DIV1024:  strobe.tapPick[3] = 1'b1;
      SEL_EXT_FALL: strobe.extFall    = 1'b1;
      SEL_EXT_RISE: strobe.extRise    = 1'b1;
      default:      ;
    endcase
  end
endmodule

// File: rtl/tcs_datapath.sv
module tcs_datapath
  import tcs_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             preClear,
  input  logic             extPin,
  input  srcStrobe_t       strobe,
  output logic [PRE_W-1:0] preVal,
  output logic             countEn
);
  logic [NUM_TAPS-1:0] tapHit;
  logic riseHit, fallHit, nextEn;

  tcs_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .preClear(preClear), .preVal(preVal), .tapHit(tapHit)
  );

  tcs_edge_sync u_sync (
    .clk(clk), .rst(rst), .extPin(extPin), .riseHit(riseHit), .fallHit(fallHit)
  );

  always_comb begin
    nextEn = strobe.direct
           | (strobe.extRise & riseHit)
           | (strobe.extFall & fallHit)
           | (|(strobe.tapPick & tapHit));
  end

  always_ff @(posedge clk) begin
    if (rst) countEn <= 1'b0;
    else     countEn <= nextEn;
  end
endmodule

// File: rtl/timer_clk_select.sv
module timer_clk_select #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] clkSel,
  input  logic       preClear,
  input  logic       extPin,
  output logic       countEn
);
  tcs_pkg::srcStrobe_t strobe;
  logic [PRE_W-1:0]    preVal;

  tcs_ctrl u_ctrl (.clkSel(clkSel), .strobe(strobe));

  tcs_datapath #(.PRE_W(PRE_W)) u_dp (
    .clk(clk), .rst(rst), .preClear(preClear), .extPin(extPin),
    .strobe(strobe), .preVal(preVal), .countEn(countEn)
  );
endmodule

// File: rtl/timer_clk_select_chk.sv
module timer_clk_select_chk #(
  parameter int PRE_W = 10,
  parameter int STB_W = tcs_pkg::STROBE_W
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       clkSel,
  input logic             preClear,
  input logic             countEn,
  input logic [PRE_W-1:0] preVal,
  input logic [STB_W-1:0] strobeBits
);
  assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(clkSel) == 3'd0 && !$past(rst)) |-> !countEn);

  assert_direct_every_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(clkSel) == 3'd1 && !$past(rst)) |-> countEn);

  assert_pre_single_R4: assert property (@(posedge clk) disable iff (rst)
    (countEn && $past(clkSel) >= 3'd2 && $past(clkSel) <= 3'd5
     && $past(clkSel, 2) == $past(clkSel)) |-> !$past(countEn));

  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobeBits));

  assert_pre_clear_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(preClear) && !$past(rst)) |-> preVal == '0);

  assert_pre_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(preClear) && !$past(rst)) |-> preVal == PRE_W'($past(preVal) + 1'b1));

  assert_ext_single_R6: assert property (@(posedge clk) disable iff (rst)
    (countEn && $past(clkSel) >= 3'd6 && $past(clkSel, 2) == $past(clkSel))
    |-> !$past(countEn));
endmodule

bind timer_clk_select timer_clk_select_chk #(.PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst(rst), .clkSel(clkSel), .preClear(preClear),
  .countEn(countEn), .preVal(preVal), .strobeBits(strobe)
);

// File: tb/sim_timer_clk_select.sv
`timescale 1ns/1ps
module sim_timer_clk_select;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] clkSel = 3'd0;
  logic preClear = 1'b0;
  logic extPin = 1'b0;
  logic countEn;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  timer_clk_select u0 (
    .clk(clk), .rst(rst), .clkSel(clkSel), .preClear(preClear),
    .extPin(extPin), .countEn(countEn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setSel(input logic [2:0] s);
    @(negedge clk);
    clkSel = s;
    repeat (3) @(negedge clk);
  endtask

  // pin edge at posedge + d ns; waits up to 8 cycles for a pulse
  task automatic extEdge(input logic val, input real d, input bit expectTick,
                         input string req);
    realtime tEdge, tUpd;
    bit seen = 0;
    @(posedge clk);
    #(d) extPin = val;
    tEdge = $realtime;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (countEn) begin seen = 1; break; end
    end
    if (expectTick) begin
      check(seen, req, "pulse after wanted edge", seen, 1);
      if (seen) begin
        @(posedge clk);
        tUpd = $realtime;
        check((tUpd - tEdge) >= 12.49 && (tUpd - tEdge) <= 17.51, "R7",
              "latency in ps", int'((tUpd - tEdge) * 1000.0), 15000);
      end
    end else begin
      check(!seen, req, "no pulse after other edge", seen, 0);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    extPin = 1'b1;
    clkSel = 3'd7;
    repeat (4) @(negedge clk);
    check(countEn == 1'b0, "R1", "countEn in reset", countEn, 0);
    #1 rst = 1'b0;
    begin
      int hits = 0;
      for (int k = 0; k < 10; k++) begin @(negedge clk); hits += countEn; end
      clkSel = 3'd6;
      for (int k = 0; k < 10; k++) begin @(negedge clk); hits += countEn; end
      check(hits == 0, "R1", "pulses after release with pin high", hits, 0);
    end
  endtask

  task automatic t_stop;
    int hits = 0;
    setSel(3'd0);
    for (int k = 0; k < 40; k++) begin @(negedge clk); hits += countEn; end
    check(hits == 0, "R2", "pulses while stopped", hits, 0);
  endtask

  task automatic t_direct;
    int hits = 0;
    setSel(3'd1);
    for (int k = 0; k < 40; k++) begin @(negedge clk); hits += countEn; end
    check(hits == 40, "R3", "pulses at direct rate", hits, 40);
  endtask

  task automatic t_ratio(input logic [2:0] s, input int n);
    int firstAt = -1, secondAt = -1, hits = 0;
    setSel(s);
    preClear = 1'b1;
    @(negedge clk);
    preClear = 1'b0;
    for (int i = 1; i <= 2 * n + 2; i++) begin
      @(negedge clk);
      if (countEn) begin
        hits++;
        if (firstAt < 0) firstAt = i;
        else if (secondAt < 0) secondAt = i;
      end
    end
    check(firstAt == n, "R5", "first divided pulse edge", firstAt, n);
    check(secondAt == 2 * n, "R4", "second divided pulse edge", secondAt, 2 * n);
    check(hits == 2, "R4", "divided pulses in window", hits, 2);
  endtask

  task automatic t_ext_latency;
    real offs [4] = '{0.5, 2.0, 3.0, 4.5};
    setSel(3'd7);
    foreach (offs[i]) begin
      extEdge(1'b1, offs[i], 1'b1, "R6");
      extEdge(1'b0, offs[i], 1'b0, "R6");
    end
    setSel(3'd6);
    foreach (offs[i]) begin
      extEdge(1'b1, offs[i], 1'b0, "R6");
      extEdge(1'b0, offs[i], 1'b1, "R6");
    end
  endtask

  task automatic t_ext_count(input logic [2:0] s);
    int hits = 0;
    setSel(s);
    for (int k = 0; k < 12; k++) begin
      @(posedge clk);
      #1 extPin = ~extPin;
      for (int j = 0; j < 4; j++) begin @(negedge clk); hits += countEn; end
    end
    for (int j = 0; j < 6; j++) begin @(negedge clk); hits += countEn; end
    check(hits == 6, "R6", "pulses for 6 pin periods", hits, 6);
  endtask

  task automatic t_ext_clear;
    setSel(3'd7);
    preClear = 1'b1;
    extEdge(1'b1, 1.0, 1'b1, "R8");
    extEdge(1'b0, 1.0, 1'b0, "R8");
    extEdge(1'b1, 3.5, 1'b1, "R8");
    preClear = 1'b0;
    extEdge(1'b0, 3.5, 1'b0, "R8");
  endtask

  task automatic t_switch;
    int hits = 0;
    @(posedge clk);
    #1 extPin = 1'b1;
    setSel(3'd0);
    repeat (5) @(negedge clk);
    clkSel = 3'd7;
    for (int k = 0; k < 5; k++) begin @(negedge clk); hits += countEn; end
    clkSel = 3'd6;
    for (int k = 0; k < 5; k++) begin @(negedge clk); hits += countEn; end
    clkSel = 3'd7;
    for (int k = 0; k < 5; k++) begin @(negedge clk); hits += countEn; end
    check(hits == 0, "R9", "pulses from select moves with steady pin", hits, 0);
  endtask

  initial begin
    t_reset();
    t_stop();
    t_direct();
    t_ratio(3'd2, 8);
    t_ratio(3'd3, 64);
    t_ratio(3'd4, 256);
    t_ratio(3'd5, 1024);
    t_stop();
    @(posedge clk);
    #1 extPin = 1'b0;
    t_ext_latency();
    t_ext_count(3'd7);
    t_ext_count(3'd6);
    t_ext_clear();
    t_switch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule